// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block drives the active-low direction pin of an external half-duplex RS-485 transceiver that sits next to a UART transmitter. It watches the transmit path and decides when the transceiver must drive the line and when it must let go of it so that data can be received. A write of a data byte into the transmitter claims the line. The line is released only when the transmit queue is empty and the serializer has finished the stop bit of its last character. Both conditions must hold in the same clock cycle.

The function is switched on by one bit of a feature configuration byte that a neighbouring register block provides. While that bit is clear, the pin stays in the receive state whatever the transmitter does. The drive window stays open across characters sent back to back, so the transceiver does not turn around between bytes of one burst. The pin comes from a flop, so it cannot glitch, and it changes exactly one clock after the condition that moves it. The serializer, the FIFO and the register decode are outside the block.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: `dir_n` encodes the transceiver direction: 1 means receive (line released) and 0 means transmit (line driven).
- R2: Reset is synchronous and active low. A clock edge that samples `rst_n` low sets `dir_n` to 1 after that edge.
- R3: The enable is bit 3 of `feat_cfg`, where 1 enables the function. The other bits of `feat_cfg` have no effect on `dir_n`.
- R4: While bit 3 of `feat_cfg` is 0, `dir_n` is 1 one clock later, whatever the values of `tx_load`, `txq_empty` and `shift_idle`.
- R5: While the function is enabled, a cycle with `tx_load` high sets `dir_n` to 0 one clock later.
- R6: While the function is enabled and `tx_load` is low, a cycle with both `txq_empty` and `shift_idle` high sets `dir_n` to 1 one clock later.
- R7: While the function is enabled and `tx_load` is low, a cycle in which `txq_empty` or `shift_idle` is low leaves `dir_n` unchanged. This includes an empty queue while the shifter is still busy, and the gaps between back-to-back characters.
- R8: A `tx_load` in the same cycle as the drain condition (`txq_empty` and `shift_idle` both high) keeps `dir_n` at 0, with no cycle at 1.
- R9: Clearing the enable bit while `dir_n` is 0 sets `dir_n` to 1 on the next clock, even with characters still pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| feat_cfg | input | CFG_W (8) | Feature configuration byte; bit 3 enables direction control |
| tx_load | input | 1 | One-cycle strobe: a data byte is written into the transmitter |
| txq_empty | input | 1 | Transmit holding register or FIFO is empty |
| shift_idle | input | 1 | Serializer is idle; the final stop bit has completed |
| dir_n | output | 1 | Transceiver direction, 1 = receive, 0 = transmit |

## Verification
Every result of this block is due exactly one clock after the cycle whose inputs produce it, because there is a single register between the inputs and `dir_n`. The bench changes inputs on the falling edge and lets the next rising edge capture them. It then compares `dir_n` on the following falling edge against a model value, computed from the previous model state and the inputs just applied. Each comparison is made half a period after the edge under test, never at an edge. This applies to the reset, enable, load, drain and hold cases alike.

// File: rtl/rs485_dir_pkg.sv
// Package: shared types for the RS-485 direction controller.
// Assumes: the state encoding matches the pin polarity, so the state flop
// can drive the pin directly.
package rs485_dir_pkg;

    // Direction state; value equals the level on the active-low pin.
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_state_t;

    // Next-state request computed from the transmit-path events.
    typedef enum logic [1:0] {
        REQ_HOLD  = 2'd0,
        REQ_DRIVE = 2'd1,
        REQ_FREE  = 2'd2
    } dir_req_t;

endpackage

// File: rtl/rs485_dir_en_decode.sv
// Module: extracts the direction-control enable from the feature byte.
// Assumes: feat_cfg is a static register value from a neighbouring decode;
// an EN_BIT outside the byte ties the enable off.
module rs485_dir_en_decode #(
    parameter int CFG_W  = 8,
    parameter int EN_BIT = 3
) (
    input  logic [CFG_W-1:0] feat_cfg,
    output logic             dir_en
);

    generate
        if (EN_BIT < CFG_W) begin : g_bit_in_range
            // Pick the single enable bit; all other bits are unused.
            assign dir_en = feat_cfg[EN_BIT];
        end else begin : g_bit_absent
            // No such bit in the byte: the function is never enabled.
            assign dir_en = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/rs485_dir_event.sv
// Module: turns transmit-path status into a direction request.
// Assumes: tx_load is a one-cycle write strobe; txq_empty and shift_idle
// are sampled together, so a release needs both in the same cycle.
module rs485_dir_event
    import rs485_dir_pkg::*;
(
    input  logic     tx_load,
    input  logic     txq_empty,
    input  logic     shift_idle,
    output dir_req_t dir_req
);

    logic drained;

    // The line may be freed only when nothing is queued or shifting.
    assign drained = txq_empty & shift_idle;

    // A new byte outranks the drain, so a write on the last stop bit holds TX.
    always_comb begin
        if (tx_load) begin
            dir_req = REQ_DRIVE;
        end else if (drained) begin
            dir_req = REQ_FREE;
        end else begin
            dir_req = REQ_HOLD;
        end
    end

endmodule

// File: rtl/rs485_dir_state.sv
// Module: the direction state flop that drives the pin.
// Assumes: synchronous active-low reset; the enable overrides every request.
module rs485_dir_state
    import rs485_dir_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     dir_en,
    input  dir_req_t dir_req,
    output logic     dir_n
);

    dir_state_t state_q;
    dir_state_t state_d;

    // Next state: disabled forces RX, otherwise follow the request.
    always_comb begin
        state_d = state_q;
        if (!dir_en) begin
            state_d = DIR_RX;
        end else begin
            case (dir_req)
                REQ_DRIVE: state_d = DIR_TX;
                REQ_FREE:  state_d = DIR_RX;
                default:   state_d = state_q;
            endcase
        end
    end

    // State register; reset releases the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIR_RX;
        end else begin
            state_q <= state_d;
        end
    end

    // The pin level equals the registered state, so no hazards reach it.
    assign dir_n = state_q;

endmodule

// File: rtl/rs485_dir_ctrl.sv
// Module: top of the RS-485 transmit direction controller.
// Assumes: the inputs come from the UART's own clock domain; the pin is
// high for receive and low for transmit.
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int CFG_W  = 8,
    parameter int EN_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] feat_cfg,
    input  logic             tx_load,
    input  logic             txq_empty,
    input  logic             shift_idle,
    output logic             dir_n
);

    logic     dir_en;
    dir_req_t dir_req;

    // Enable extraction from the feature byte.
    rs485_dir_en_decode #(
        .CFG_W (CFG_W),
        .EN_BIT(EN_BIT)
    ) en_dec_i (
        .feat_cfg(feat_cfg),
        .dir_en  (dir_en)
    );

    // Transmit-path event classification.
    rs485_dir_event evt_i (
        .tx_load   (tx_load),
        .txq_empty (txq_empty),
        .shift_idle(shift_idle),
        .dir_req   (dir_req)
    );

    // Registered direction state.
    rs485_dir_state st_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_en (dir_en),
        .dir_req(dir_req),
        .dir_n  (dir_n)
    );

endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
// Checker: port-level properties of the direction controller, bound to the top.
// Assumes: EN_BIT lies inside feat_cfg.
module rs485_dir_ctrl_chk #(
    parameter int CFG_W  = 8,
    parameter int EN_BIT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] feat_cfg,
    input logic             tx_load,
    input logic             txq_empty,
    input logic             shift_idle,
    input logic             dir_n
);

    logic en;
    assign en = feat_cfg[EN_BIT];

    AST_RESET_RX: assert property (@(posedge clk) !rst_n |=> dir_n); // R2

    AST_DISABLED_RX: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> dir_n); // R4

    AST_LOAD_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tx_load) |=> !dir_n); // R5

    AST_DRAIN_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tx_load && txq_empty && shift_idle) |=> dir_n); // R6

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tx_load && !(txq_empty && shift_idle)) |=> $stable(dir_n)); // R7

    AST_LOAD_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tx_load && txq_empty && shift_idle) |=> !dir_n); // R8

    AST_DISABLE_MID_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_n && !en) |=> dir_n); // R9

endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(
    .CFG_W (CFG_W),
    .EN_BIT(EN_BIT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .feat_cfg  (feat_cfg),
    .tx_load   (tx_load),
    .txq_empty (txq_empty),
    .shift_idle(shift_idle),
    .dir_n     (dir_n)
);

// File: tb/rs485_dir_ctrl_tb.sv
// Bench: directed corner cases plus seeded random stimulus, checked against
// a reference model function computed from the requirements.
module rs485_dir_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] feat_cfg = 8'h00;
    logic       tx_load = 1'b0;
    logic       txq_empty = 1'b1;
    logic       shift_idle = 1'b1;
    logic       dir_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic exp_dir = 1'b1;

    always #10 clk = ~clk; // 50 MHz

    rs485_dir_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .feat_cfg  (feat_cfg),
        .tx_load   (tx_load),
        .txq_empty (txq_empty),
        .shift_idle(shift_idle),
        .dir_n     (dir_n)
    );

    // Reference model of the next pin level.
    function automatic logic model_next(logic prev, logic rst_lo, logic [7:0] cfg,
                                        logic ld, logic emp, logic idl);
        if (!rst_lo) return 1'b1;             // R2
        if (!cfg[3]) return 1'b1;             // R4, R9
        if (ld) return 1'b0;                  // R5, R8
        if (emp && idl) return 1'b1;          // R6
        return prev;                          // R7
    endfunction

    // Requirement tag for a given stimulus.
    function automatic string tag_for(logic prev, logic rst_lo, logic [7:0] cfg,
                                      logic ld, logic emp, logic idl);
        if (!rst_lo) return "R2";
        if (!cfg[3]) return prev ? "R4" : "R9";
        if (ld && emp && idl) return "R8";
        if (ld) return "R5";
        if (emp && idl) return "R6";
        return "R7";
    endfunction

    // Apply inputs at a falling edge, let one rising edge pass, check.
    task automatic apply(logic r, logic [7:0] cfg, logic ld, logic emp, logic idl,
                         string tag);
        string t;
        rst_n = r; feat_cfg = cfg; tx_load = ld; txq_empty = emp; shift_idle = idl;
        t = (tag == "") ? tag_for(exp_dir, r, cfg, ld, emp, idl) : tag;
        exp_dir = model_next(exp_dir, r, cfg, ld, emp, idl);
        @(negedge clk);
        n_tests++;
        if (dir_n !== exp_dir) begin
            n_fail++;
            $display("FAIL %s: dir_n=%b expected %b (cfg=%h ld=%b emp=%b idl=%b)",
                     t, dir_n, exp_dir, cfg, ld, emp, idl);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R2: reset state, R1 receive level
        apply(1'b0, 8'h08, 1'b1, 1'b0, 1'b0, "R2");
        apply(1'b0, 8'h08, 1'b0, 1'b1, 1'b1, "R1");
        // R4: disabled ignores loads and busy status
        apply(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, "R4");
        apply(1'b1, 8'hF7, 1'b1, 1'b0, 1'b0, "R3");   // all other bits set
        apply(1'b1, 8'hF7, 1'b0, 1'b0, 1'b0, "R3");
        // R5: load drives the line (R1 transmit level)
        apply(1'b1, 8'h08, 1'b1, 1'b0, 1'b0, "R5");
        // R7: back-to-back: queue empties, shifter still busy
        apply(1'b1, 8'h08, 1'b0, 1'b0, 1'b0, "R7");
        apply(1'b1, 8'h08, 1'b0, 1'b1, 1'b0, "R7");
        apply(1'b1, 8'h08, 1'b0, 1'b0, 1'b1, "R7");
        // R8: load exactly on the drain cycle
        apply(1'b1, 8'h08, 1'b1, 1'b1, 1'b1, "R8");
        apply(1'b1, 8'h08, 1'b0, 1'b1, 1'b0, "R7");
        // R6: drain releases
        apply(1'b1, 8'h08, 1'b0, 1'b1, 1'b1, "R6");
        apply(1'b1, 8'h08, 1'b0, 1'b0, 1'b0, "R7");   // stays receive
        // R9: clear enable mid-transmission
        apply(1'b1, 8'hFF, 1'b1, 1'b0, 1'b0, "R5");
        apply(1'b1, 8'hF7, 1'b0, 1'b0, 1'b0, "R9");
        // R3: other bits irrelevant while enabled
        apply(1'b1, 8'h08, 1'b1, 1'b0, 1'b0, "R5");
        apply(1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, "R3");
        apply(1'b1, 8'hF8, 1'b0, 1'b1, 1'b1, "R3");
        // R2: reset during transmission
        apply(1'b1, 8'h08, 1'b1, 1'b0, 1'b0, "R5");
        apply(1'b0, 8'h08, 1'b1, 1'b0, 1'b0, "R2");
        // Random traffic, biased so the enable is usually on.
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] cfg;
            logic r;
            cfg = 8'($urandom);
            cfg[3] = ($urandom_range(0, 9) != 0);
            r = ($urandom_range(0, 199) != 0);
            apply(r, cfg, ($urandom_range(0, 5) == 0),
                  ($urandom_range(0, 2) != 0), ($urandom_range(0, 2) != 0), "");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule